// File: doc/BRIEF.md
# Adder Self-Test Operand Sequencer

This block feeds deterministic operand pairs and a carry-in to an n-bit carry-lookahead adder while that adder is being tested on line. It produces no expected results: the adder's sum is judged elsewhere, by comparing it with a second copy of the adder. The sequencer is a walking shift register and a session counter of log2(4n) bits. One session lasts 4n cycles and is split into three parts by the counter's two top bits.

In the first quarter, a single one walks up operand A while B and the carry-in are zero. In the second quarter, the same one walks up both operands with the carry-in set. In the second half, the outputs form n two-vector pairs that test carry-chain delay. Pair k first applies a block of ones in bits 0..k with the carry-in low. It then applies the same operands with the carry-in high, so a carry runs through k+1 bit positions. A flag marks the second vector of each pair, and a one-cycle done strobe marks the last cycle of a session.

A control unit starts a session by raising start. If start is still high when a session ends, the next session follows with no gap. If start is low at that point, the block returns to idle.

Top module: `adder_tpg`

## Requirements
- R1: While idle, and after reset, op_a_o, op_b_o, carry_in_o, pair_second_o and done_o are all zero.
- R2: When start_i is sampled high while idle, session cycle 0 appears on the outputs in the following clock cycle. While start_i stays low, the block stays idle.
- R3: In session cycles i = 0..n-1, op_a_o has only bit i set, op_b_o is zero, carry_in_o is 0 and pair_second_o is 0.
- R4: In session cycles i = n..2n-1, op_a_o and op_b_o both have only bit i-n set, carry_in_o is 1 and pair_second_o is 0.
- R5: In session cycles i = 2n..4n-1, pair index k = (i-2n)/2. op_a_o holds ones in bits 0..k and zeros above, and op_b_o is zero. On even i (first vector of the pair), carry_in_o and pair_second_o are 0. On odd i (second vector), both are 1 and op_a_o is unchanged from the first vector.
- R6: done_o is 1 in session cycle 4n-1 only, for exactly one cycle per session.
- R7: If start_i is high in cycle 4n-1, the next cycle is session cycle 0 of a new session. Otherwise the block is idle in the next cycle.
- R8: start_i has no effect during session cycles 0..4n-2: the session advances by one cycle per clock.
- R9: rst_ni is a synchronous, active-low reset. Asserting it at any point returns the block to idle in the next cycle.
- R10: WIDTH must be a power of two and at least 2. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start a session, or keep sessions running |
| op_a_o | output | WIDTH | Operand A for the adder under test |
| op_b_o | output | WIDTH | Operand B for the adder under test |
| carry_in_o | output | 1 | Carry-in for the adder under test |
| pair_second_o | output | 1 | High on the second vector of a delay-test pair |
| done_o | output | 1 | One-cycle strobe in the last cycle of a session |

## Verification
The in-line assertions check the following on every cycle: the idle outputs are quiet, operand A is one-hot in the walking quarters, both operands match in the second quarter, and a pair's second vector carries the carry-in and keeps operand A stable. They also check that the counter steps by one and ignores start, that done is a single-cycle strobe, and that the block drops to idle when start is low at the end of a session. Only the bench's scenarios can show the exact value of every vector across a full session. The same holds for the gapless back-to-back session, the mid-session reset, and the point at which the first vector appears after start.

// File: rtl/adder_tpg_pkg.sv
package adder_tpg_pkg;

   // Phase taken from the two top bits of the session counter
   typedef enum logic [1:0] {
      PH_WALK_A  = 2'b00,
      PH_WALK_AB = 2'b01,
      PH_PAIR_LO = 2'b10,
      PH_PAIR_HI = 2'b11
   } tpg_phase_e;

   function automatic logic phase_is_pair(tpg_phase_e ph);
      return ph[1];
   endfunction

endpackage

// File: rtl/adder_tpg_seq.sv
// Session counter, run control and shift-register steering
module adder_tpg_seq
   import adder_tpg_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int CNT_W = $clog2(4 * WIDTH)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   output logic       running_o,
   output tpg_phase_e phase_o,
   output logic       pair_bit_o,
   output logic       done_o,
   output logic       sr_load_o,
   output logic       sr_shift_o,
   output logic       sr_clear_o,
   output logic       sr_fill_o
);

   localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(4 * WIDTH - 1);
   localparam logic [CNT_W-1:0] WALK_A_END = CNT_W'(WIDTH - 1);
   localparam logic [CNT_W-1:0] WALK_B_END = CNT_W'(2 * WIDTH - 1);

   logic             running_q;
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         running_q <= 1'b0;
         count_q   <= '0;
      end else if (!running_q) begin
         running_q <= start_i;
         count_q   <= '0;
      end else if (count_q == CNT_LAST) begin
         running_q <= start_i;
         count_q   <= '0;
      end else begin
         count_q   <= count_q + 1'b1;
      end
   end

   assign running_o  = running_q;
   assign phase_o    = tpg_phase_e'(count_q[CNT_W-1 -: 2]);
   assign pair_bit_o = count_q[0];
   assign done_o     = running_q && (count_q == CNT_LAST);

   // Steering: clear wins over load, load wins over shift
   assign sr_clear_o = done_o && !start_i;
   assign sr_load_o  = (!running_q && start_i)
                    || (running_q && (count_q == WALK_A_END || count_q == WALK_B_END))
                    || (done_o && start_i);
   assign sr_shift_o = running_q && (!phase_is_pair(phase_o) || count_q[0]);
   assign sr_fill_o  = phase_is_pair(phase_o);

   // R6: done lasts one cycle
   assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8: start does not disturb a running session
   assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_q && !done_o) |=> (running_q && count_q == $past(count_q) + 1'b1));

   // R7: end of session with start low goes idle
   assert_end_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> !running_q);

endmodule

// File: rtl/adder_tpg_shreg.sv
// Walking shift register, one generated cell per bit
module adder_tpg_shreg #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic             clear_i,
   input  logic             fill_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q_q;
   logic [WIDTH-1:0] d;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic shift_in;
      if (i == 0) begin : g_head
         assign shift_in = fill_i;
      end else begin : g_body
         assign shift_in = q_q[i-1];
      end
      assign d[i] = clear_i ? 1'b0
                  : load_i  ? 1'(i == 0)
                  : shift_i ? shift_in
                  : q_q[i];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= d;
   end

   assign q_o = q_q;

endmodule

// File: rtl/adder_tpg_map.sv
// Routes the shift register onto the operand ports for each phase
module adder_tpg_map
   import adder_tpg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             running_i,
   input  tpg_phase_e       phase_i,
   input  logic             pair_bit_i,
   input  logic [WIDTH-1:0] pattern_i,
   output logic [WIDTH-1:0] op_a_o,
   output logic [WIDTH-1:0] op_b_o,
   output logic             carry_in_o,
   output logic             pair_second_o
);

   always_comb begin
      op_a_o        = '0;
      op_b_o        = '0;
      carry_in_o    = 1'b0;
      pair_second_o = 1'b0;
      if (running_i) begin
         unique case (phase_i)
            PH_WALK_A: begin
               op_a_o = pattern_i;
            end
            PH_WALK_AB: begin
               op_a_o     = pattern_i;
               op_b_o     = pattern_i;
               carry_in_o = 1'b1;
            end
            default: begin
               op_a_o        = pattern_i;
               carry_in_o    = pair_bit_i;
               pair_second_o = pair_bit_i;
            end
         endcase
      end
   end

endmodule

// File: rtl/adder_tpg.sv
module adder_tpg
   import adder_tpg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic [WIDTH-1:0] op_a_o,
   output logic [WIDTH-1:0] op_b_o,
   output logic             carry_in_o,
   output logic             pair_second_o,
   output logic             done_o
);

   // R10: the phase decode takes the counter's top bits, so WIDTH must be 2**m
   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("adder_tpg: WIDTH must be a power of two and at least 2");
   end

   logic             running;
   tpg_phase_e       phase;
   logic             pair_bit;
   logic             sr_load, sr_shift, sr_clear, sr_fill;
   logic [WIDTH-1:0] pattern;

   adder_tpg_seq #(.WIDTH(WIDTH)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .running_o  (running),
      .phase_o    (phase),
      .pair_bit_o (pair_bit),
      .done_o     (done_o),
      .sr_load_o  (sr_load),
      .sr_shift_o (sr_shift),
      .sr_clear_o (sr_clear),
      .sr_fill_o  (sr_fill)
   );

   adder_tpg_shreg #(.WIDTH(WIDTH)) u_shreg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (sr_load),
      .shift_i (sr_shift),
      .clear_i (sr_clear),
      .fill_i  (sr_fill),
      .q_o     (pattern)
   );

   adder_tpg_map #(.WIDTH(WIDTH)) u_map (
      .running_i     (running),
      .phase_i       (phase),
      .pair_bit_i    (pair_bit),
      .pattern_i     (pattern),
      .op_a_o        (op_a_o),
      .op_b_o        (op_b_o),
      .carry_in_o    (carry_in_o),
      .pair_second_o (pair_second_o)
   );

   // R1: idle outputs stay quiet
   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !running |-> (op_a_o == '0 && op_b_o == '0 && !carry_in_o && !pair_second_o));

   // R3: a single one walks in the first quarter
   assert_walk_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && phase == PH_WALK_A) |-> ($countones(op_a_o) == 1 && op_b_o == '0));

   // R4: both operands carry the same single one, with carry-in set
   assert_walk_ab_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && phase == PH_WALK_AB) |-> ($countones(op_a_o) == 1 && op_a_o == op_b_o && carry_in_o));

   // R5: the first vector of a pair is followed by the launch vector on the same operand
   assert_pair_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && phase_is_pair(phase) && !pair_second_o) |=> (pair_second_o && carry_in_o && $stable(op_a_o)));

   // R5: the launch vector has operand B at zero
   assert_launch_cin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_second_o |-> (carry_in_o && op_b_o == '0 && op_a_o[0]));

endmodule

// File: tb/adder_tpg_bench.sv
module adder_tpg_bench;

   localparam int W = 8;
   localparam int SESSION = 4 * W;
   localparam int VW = 2 * W + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] op_a, op_b;
   logic         cin, second, done;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   adder_tpg #(.WIDTH(W)) u_adder_tpg (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .op_a_o(op_a), .op_b_o(op_b), .carry_in_o(cin),
      .pair_second_o(second), .done_o(done)
   );

   // Spot vectors: {cycle, A, B, cin, second, done}
   localparam logic [26:0] SPOT [10] = '{
      {8'd0,  8'h01, 8'h00, 3'b000},
      {8'd7,  8'h80, 8'h00, 3'b000},
      {8'd8,  8'h01, 8'h01, 3'b100},
      {8'd15, 8'h80, 8'h80, 3'b100},
      {8'd16, 8'h01, 8'h00, 3'b000},
      {8'd17, 8'h01, 8'h00, 3'b110},
      {8'd18, 8'h03, 8'h00, 3'b000},
      {8'd21, 8'h07, 8'h00, 3'b110},
      {8'd30, 8'hFF, 8'h00, 3'b000},
      {8'd31, 8'hFF, 8'h00, 3'b111}
   };

   // Vector expected in session cycle i, following R3..R6
   function automatic logic [VW-1:0] model(int i);
      logic [W-1:0] a = '0, b = '0;
      logic c = 1'b0, s = 1'b0, d;
      if (i < W) begin
         a = W'(1) << i;
      end else if (i < 2 * W) begin
         a = W'(1) << (i - W); b = a; c = 1'b1;
      end else begin
         a = {W{1'b1}} >> (W - 1 - (i - 2 * W) / 2);
         c = (i % 2) == 1; s = c;
      end
      d = (i == SESSION - 1);
      return {a, b, c, s, d};
   endfunction

   function automatic logic [VW-1:0] observed();
      return {op_a, op_b, cin, second, done};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check(observed() == '0, tag, 64'(observed()), 64'd0);
   endtask

   initial begin
      int dones;
      // R1, R9: reset state
      repeat (3) @(negedge clk);
      check_idle("R1 R9 during reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R1 R2 idle without start");

      // R2..R6: one full session, start as a single pulse
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dones = 0;
      for (int i = 0; i < SESSION; i++) begin
         check(observed() == model(i), "R3 R4 R5 R6 session vector", 64'(observed()), 64'(model(i)));
         for (int t = 0; t < 10; t++) begin
            if (int'(SPOT[t][26:19]) == i)
               check(observed() == SPOT[t][18:0], "R2 R5 spot vector", 64'(observed()), 64'(SPOT[t][18:0]));
         end
         if (done) dones++;
         @(negedge clk);
      end
      check(dones == 1, "R6 done count", 64'(dones), 64'd1);
      check_idle("R7 idle after session");

      // R7: start held high, back-to-back sessions
      start = 1'b1;
      @(negedge clk);
      repeat (SESSION - 1) @(negedge clk);
      check(observed() == model(SESSION - 1), "R7 last cycle", 64'(observed()), 64'(model(SESSION - 1)));
      @(negedge clk);
      check(observed() == model(0), "R7 wrap to cycle 0", 64'(observed()), 64'(model(0)));
      start = 1'b0;
      repeat (5) @(negedge clk);
      check(observed() == model(5), "R8 cycle 5", 64'(observed()), 64'(model(5)));

      // R8: start pulse mid-session is ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(observed() == model(6), "R8 no restart", 64'(observed()), 64'(model(6)));
      repeat (14) @(negedge clk);
      check(observed() == model(20), "R8 steady advance", 64'(observed()), 64'(model(20)));

      // R9: reset mid-session
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_idle("R9 reset mid-session");
      @(negedge clk);
      check_idle("R9 stays idle");

      $display("%0d/%0d checks passed", checks - fails, checks);
      finished = 1;
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule